// File: doc/BRIEF.md
# Video DMA Source Engine

This block produces the transfer stream of a video DMA. While its run flag is set it looks at every access slot of the scan line and, when the slot may be used, produces one value. It then pushes that value into the shared write queue as an entry whose due time lies a fixed number of slots ahead. It never writes video memory itself. The value comes from one of three places:

- an external memory read port, for a bus transfer;
- the last word written through the host data port, for a fill;
- a read of the destination's own memory, for a copy.

The engine is configured through one load strobe. That strobe sets the source pointer, the transfer length, the auto-increment step, the destination address and the command code. Bus transfers and copies start on the load strobe. A fill starts on a later host data-port write. Around the engine, the scan logic supplies the slot number and the line width mode, and the write queue supplies its full signal and a pulse for each slot it left unused.

Top module: `vdma_source_engine`

## Requirements
- R1: Bits 23:22 of the source pointer (the top two bits of its high byte) pick the mode. The value 00 or 01 gives a bus transfer, 10 gives a fill and 11 gives a copy. A push happens only in a cycle with `slot_en` high while `busy` is high. A bus push carries the value on `ext_data`, with `q_partial` low.
- R2: No push happens in a refresh slot. With `wide_mode` high, the refresh slots are 37, 69, 102, 133, 165 and 197, plus every slot from 210 upward. With `wide_mode` low, they are 24, 56, 88, 120 and 152.
- R3: A bus transfer also skips a slot whose predecessor (slot number minus one) is a refresh slot. Slot 0 is always usable.
- R4: A copy step needs an unused-slot pulse received in an earlier slot, and each step consumes that one pulse. The command target (`cmd[3:0]`: 0001 main RAM, 0011 colour RAM, 0101 scroll RAM) selects what is read:
  - main RAM reads `loc_sel`=0 at source bits 15:0;
  - colour RAM reads `loc_sel`=1 at the low source byte masked to the colour depth of 64;
  - scroll RAM reads `loc_sel`=2 at the low source byte masked to 6 bits. An index of 40 or more pushes 0 with no read.
- R5: A host data-port write starts a fill when fill mode is selected and command bit 5 is set. The fill pushes that write's data word with `q_partial` high. For a main RAM target the pushed value is the high byte, zero-extended. The first push comes no earlier than the next slot.
- R6: Each push carries `q_due` equal to the number of slots seen since reset plus 3, modulo 256. Nothing is pushed while `q_full` is high.
- R7: After each push, source bits 15:0 increment, so the low byte carries into the middle byte. The destination advances by the auto-increment value and the length decrements. When a push takes the length to zero, `busy` falls and command bits 5:4 clear.
- R8: A data-port write is refused (`dp_refused` high) while a bus transfer or copy runs. It is accepted during a fill.
- R9: A load whose command has bit 5 set starts the run at once for a bus transfer or copy, but not for a fill.
- R10: After reset, `busy`, `q_push`, `len_left` and `cmd_now` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_en | input | 1 | Marks the cycle as an access slot |
| slot_num | input | 8 | Number of the current slot in the line |
| wide_mode | input | 1 | Wide line mode selects the wide refresh pattern |
| unused_slot | input | 1 | Write queue left this slot idle |
| cfg_load | input | 1 | Load all configuration fields |
| cfg_src | input | 24 | Source pointer; bits 23:22 are the mode |
| cfg_len | input | 16 | Transfer count |
| cfg_inc | input | 8 | Destination auto-increment |
| cfg_dest | input | 16 | Destination address |
| cfg_cmd | input | 6 | Command code; bits 3:0 target, bit 5 go |
| dp_wr | input | 1 | Host data-port write |
| dp_data | input | 16 | Host data-port word |
| dp_refused | output | 1 | The data-port write is refused |
| ext_rd | output | 1 | External memory read strobe |
| ext_addr | output | 23 | External memory word address |
| ext_data | input | 16 | External memory read data, same cycle |
| loc_rd | output | 1 | Video memory read strobe for copy |
| loc_sel | output | 2 | Memory chosen for the copy read |
| loc_addr | output | 16 | Copy read address |
| loc_data | input | 16 | Copy read data, same cycle |
| q_full | input | 1 | Write queue has no room |
| q_push | output | 1 | Push an entry into the queue |
| q_addr | output | 16 | Entry destination address |
| q_data | output | 16 | Entry value |
| q_cmd | output | 6 | Entry command code |
| q_partial | output | 1 | Entry is marked as already half done |
| q_due | output | 8 | Slot stamp at which the entry becomes due |
| busy | output | 1 | Run flag |
| len_left | output | 16 | Remaining transfer count |
| cmd_now | output | 6 | Current command code |
| dest_now | output | 16 | Current destination address |

## Verification
The bench walks slot numbers around each refresh slot in both line widths. This exposes a decoder that blocks the wrong slot, or that fails to skip the slot after a refresh for bus reads. It also exposes slot 0 being treated as following slot 255. A source pointer starting at low byte FE checks the carry into the middle byte; a design that wraps only the low byte would repeat addresses. The bench runs the copy path with and without an unused-slot pulse and with a scroll index past the end of that RAM. A design that ignores the flag, or never consumes it, copies too often, and one that reads out of range returns stray data. For fills, the bench checks that nothing is pushed in the triggering slot and that a main RAM target gets the high byte, with the partial mark set. It also checks that the final push drops the run flag and the go bits of the command.

// File: rtl/vdma_pkg.sv
package vdma_pkg;

   typedef enum logic [1:0] {
      MODE_BUS_LO = 2'b00,
      MODE_BUS_HI = 2'b01,
      MODE_FILL   = 2'b10,
      MODE_COPY   = 2'b11
   } vdma_mode_e;

   localparam logic [3:0] TGT_MAIN   = 4'b0001;
   localparam logic [3:0] TGT_COLOR  = 4'b0011;
   localparam logic [3:0] TGT_SCROLL = 4'b0101;

   localparam logic [1:0] SEL_MAIN   = 2'd0;
   localparam logic [1:0] SEL_COLOR  = 2'd1;
   localparam logic [1:0] SEL_SCROLL = 2'd2;

   localparam int CMD_GO_BIT = 5;

   function automatic logic mode_is_bus(input vdma_mode_e m);
      return (m == MODE_BUS_LO) || (m == MODE_BUS_HI);
   endfunction

endpackage

// File: rtl/vdma_refresh_decode.sv
module vdma_refresh_decode #(
   parameter int SLOT_W       = 8,
   parameter int REFRESH_TAIL = 210
) (
   input  logic [SLOT_W-1:0] slot,
   input  logic              wide,
   output logic              is_refresh
);
   localparam int N_WIDE   = 6;
   localparam int N_NARROW = 5;
   localparam int WIDE_SLOTS   [N_WIDE]   = '{37, 69, 102, 133, 165, 197};
   localparam int NARROW_SLOTS [N_NARROW] = '{24, 56, 88, 120, 152};

   logic [N_WIDE-1:0]   hit_wide;
   logic [N_NARROW-1:0] hit_narrow;
   logic                hit_tail;

   for (genvar i = 0; i < N_WIDE; i++) begin : g_wide
      assign hit_wide[i] = (int'(slot) == WIDE_SLOTS[i]);
   end

   for (genvar j = 0; j < N_NARROW; j++) begin : g_narrow
      assign hit_narrow[j] = (int'(slot) == NARROW_SLOTS[j]);
   end

   if (REFRESH_TAIL < (1 << SLOT_W)) begin : g_tail
      assign hit_tail = (int'(slot) >= REFRESH_TAIL);
   end else begin : g_no_tail
      assign hit_tail = 1'b0;
   end

   assign is_refresh = wide ? ((|hit_wide) | hit_tail) : (|hit_narrow);

endmodule

// File: rtl/vdma_source_mux.sv
module vdma_source_mux
   import vdma_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter int ADDR_W       = 16,
   parameter int CRAM_DEPTH   = 64,
   parameter int SCROLL_DEPTH = 40
) (
   input  vdma_mode_e        mode,
   input  logic [3:0]        target,
   input  logic [7:0]        src_mid,
   input  logic [7:0]        src_lo,
   input  logic [DATA_W-1:0] fill_word,
   input  logic [DATA_W-1:0] ext_data,
   input  logic [DATA_W-1:0] loc_data,
   input  logic              step_ok,
   input  logic              bus_ok,
   input  logic              idle_flag,
   output logic              fire,
   output logic [DATA_W-1:0] value,
   output logic              partial,
   output logic              ext_rd,
   output logic              loc_rd,
   output logic [1:0]        loc_sel,
   output logic [ADDR_W-1:0] loc_addr,
   output logic              consume
);
   localparam logic [7:0] CRAM_MASK = 8'(CRAM_DEPTH - 1);
   localparam int         HI_LSB    = DATA_W - 8;

   logic [5:0] scroll_idx;
   assign scroll_idx = src_lo[5:0];

   always_comb begin
      fire     = 1'b0;
      value    = '0;
      partial  = 1'b0;
      ext_rd   = 1'b0;
      loc_rd   = 1'b0;
      loc_sel  = SEL_MAIN;
      loc_addr = '0;
      consume  = 1'b0;
      unique case (mode)
         MODE_BUS_LO, MODE_BUS_HI: begin
            if (step_ok && bus_ok) begin
               ext_rd = 1'b1;
               fire   = 1'b1;
               value  = ext_data;
            end
         end
         MODE_FILL: begin
            if (step_ok) begin
               fire    = 1'b1;
               partial = 1'b1;
               if (target == TGT_MAIN) begin
                  value = DATA_W'(fill_word[DATA_W-1:HI_LSB]);
               end else begin
                  value = fill_word;
               end
            end
         end
         MODE_COPY: begin
            if (step_ok && idle_flag) begin
               fire    = 1'b1;
               consume = 1'b1;
               case (target)
                  TGT_MAIN: begin
                     loc_rd   = 1'b1;
                     loc_sel  = SEL_MAIN;
                     loc_addr = ADDR_W'({src_mid, src_lo});
                     value    = loc_data;
                  end
                  TGT_COLOR: begin
                     loc_rd   = 1'b1;
                     loc_sel  = SEL_COLOR;
                     loc_addr = ADDR_W'(src_lo & CRAM_MASK);
                     value    = loc_data;
                  end
                  TGT_SCROLL: begin
                     if (int'(scroll_idx) < SCROLL_DEPTH) begin
                        loc_rd   = 1'b1;
                        loc_sel  = SEL_SCROLL;
                        loc_addr = ADDR_W'(scroll_idx);
                        value    = loc_data;
                     end else begin
                        value = '0;
                     end
                  end
                  default: value = '0;
               endcase
            end
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/vdma_pointer_regs.sv
module vdma_pointer_regs #(
   parameter int SRC_W  = 24,
   parameter int LEN_W  = 16,
   parameter int ADDR_W = 16,
   parameter int INC_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [SRC_W-1:0]  load_src,
   input  logic [LEN_W-1:0]  load_len,
   input  logic [ADDR_W-1:0] load_dest,
   input  logic [INC_W-1:0]  load_inc,
   input  logic              advance,
   output logic [SRC_W-1:0]  src,
   output logic [ADDR_W-1:0] dest,
   output logic [LEN_W-1:0]  len,
   output logic              last_step
);
   logic [INC_W-1:0] inc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src   <= '0;
         dest  <= '0;
         len   <= '0;
         inc_q <= '0;
      end else if (load) begin
         src   <= load_src;
         dest  <= load_dest;
         len   <= load_len;
         inc_q <= load_inc;
      end else if (advance) begin
         src[15:0] <= src[15:0] + 16'd1;
         dest      <= dest + ADDR_W'(inc_q);
         len       <= len - LEN_W'(1);
      end
   end

   assign last_step = (len == LEN_W'(1));

endmodule

// File: rtl/vdma_source_engine.sv
module vdma_source_engine
   import vdma_pkg::*;
#(
   parameter int SLOT_W       = 8,
   parameter int TS_W         = 8,
   parameter int LATENCY      = 3,
   parameter int LEN_W        = 16,
   parameter int ADDR_W       = 16,
   parameter int DATA_W       = 16,
   parameter int INC_W        = 8,
   parameter int CMD_W        = 6,
   parameter int CRAM_DEPTH   = 64,
   parameter int SCROLL_DEPTH = 40,
   parameter int REFRESH_TAIL = 210
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slot_en,
   input  logic [SLOT_W-1:0] slot_num,
   input  logic              wide_mode,
   input  logic              unused_slot,
   input  logic              cfg_load,
   input  logic [23:0]       cfg_src,
   input  logic [LEN_W-1:0]  cfg_len,
   input  logic [INC_W-1:0]  cfg_inc,
   input  logic [ADDR_W-1:0] cfg_dest,
   input  logic [CMD_W-1:0]  cfg_cmd,
   input  logic              dp_wr,
   input  logic [DATA_W-1:0] dp_data,
   output logic              dp_refused,
   output logic              ext_rd,
   output logic [22:0]       ext_addr,
   input  logic [DATA_W-1:0] ext_data,
   output logic              loc_rd,
   output logic [1:0]        loc_sel,
   output logic [ADDR_W-1:0] loc_addr,
   input  logic [DATA_W-1:0] loc_data,
   input  logic              q_full,
   output logic              q_push,
   output logic [ADDR_W-1:0] q_addr,
   output logic [DATA_W-1:0] q_data,
   output logic [CMD_W-1:0]  q_cmd,
   output logic              q_partial,
   output logic [TS_W-1:0]   q_due,
   output logic              busy,
   output logic [LEN_W-1:0]  len_left,
   output logic [CMD_W-1:0]  cmd_now,
   output logic [ADDR_W-1:0] dest_now
);
   localparam int SRC_W = 24;
   localparam logic [CMD_W-1:0] CMD_KEEP = CMD_W'(4'hF);

   if (DATA_W != 16) begin : g_bad_data
      $error("vdma_source_engine: DATA_W must be 16");
   end
   if (CMD_W <= CMD_GO_BIT) begin : g_bad_cmd
      $error("vdma_source_engine: CMD_W too small for the go bit");
   end
   if ((CRAM_DEPTH & (CRAM_DEPTH - 1)) != 0 || CRAM_DEPTH > 256) begin : g_bad_cram
      $error("vdma_source_engine: CRAM_DEPTH must be a power of two up to 256");
   end
   if (SCROLL_DEPTH > 64 || SCROLL_DEPTH < 1) begin : g_bad_scroll
      $error("vdma_source_engine: SCROLL_DEPTH must be 1..64");
   end
   if (LATENCY >= (1 << TS_W)) begin : g_bad_lat
      $error("vdma_source_engine: LATENCY does not fit TS_W");
   end
   if (SLOT_W < 8) begin : g_bad_slot
      $error("vdma_source_engine: SLOT_W must hold slot 255");
   end

   logic [SRC_W-1:0]  src_q;
   logic [ADDR_W-1:0] dest_q;
   logic [LEN_W-1:0]  len_q;
   logic              last_step;
   logic              busy_q;
   logic [CMD_W-1:0]  cmd_q;
   logic [DATA_W-1:0] fill_word_q;
   logic              idle_flag_q;
   logic [TS_W-1:0]   ts_q;
   vdma_mode_e        mode_w;

   logic ref_now, ref_prev, bus_ok, step_ok;
   logic fire, consume, partial_w;
   logic [DATA_W-1:0] value_w;
   logic dp_accept, fill_go, cfg_go;

   assign mode_w = vdma_mode_e'(src_q[23:22]);

   vdma_refresh_decode #(.SLOT_W(SLOT_W), .REFRESH_TAIL(REFRESH_TAIL)) u_ref_now (
      .slot(slot_num), .wide(wide_mode), .is_refresh(ref_now)
   );

   vdma_refresh_decode #(.SLOT_W(SLOT_W), .REFRESH_TAIL(REFRESH_TAIL)) u_ref_prev (
      .slot(slot_num - SLOT_W'(1)), .wide(wide_mode), .is_refresh(ref_prev)
   );

   assign bus_ok  = (slot_num == '0) || !ref_prev;
   assign step_ok = slot_en && busy_q && !ref_now && !q_full;

   vdma_source_mux #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W),
      .CRAM_DEPTH(CRAM_DEPTH), .SCROLL_DEPTH(SCROLL_DEPTH)
   ) u_mux (
      .mode(mode_w), .target(cmd_q[3:0]),
      .src_mid(src_q[15:8]), .src_lo(src_q[7:0]),
      .fill_word(fill_word_q), .ext_data(ext_data), .loc_data(loc_data),
      .step_ok(step_ok), .bus_ok(bus_ok), .idle_flag(idle_flag_q),
      .fire(fire), .value(value_w), .partial(partial_w),
      .ext_rd(ext_rd), .loc_rd(loc_rd), .loc_sel(loc_sel), .loc_addr(loc_addr),
      .consume(consume)
   );

   vdma_pointer_regs #(
      .SRC_W(SRC_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W), .INC_W(INC_W)
   ) u_ptr (
      .clk(clk), .rst_n(rst_n),
      .load(cfg_load), .load_src(cfg_src), .load_len(cfg_len),
      .load_dest(cfg_dest), .load_inc(cfg_inc),
      .advance(fire),
      .src(src_q), .dest(dest_q), .len(len_q), .last_step(last_step)
   );

   assign dp_refused = dp_wr && busy_q && (mode_w != MODE_FILL);
   assign dp_accept  = dp_wr && !dp_refused;
   assign fill_go    = dp_accept && cmd_q[CMD_GO_BIT] && (mode_w == MODE_FILL);
   assign cfg_go     = cfg_load && cfg_cmd[CMD_GO_BIT] &&
                       (vdma_mode_e'(cfg_src[23:22]) != MODE_FILL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q      <= 1'b0;
         cmd_q       <= '0;
         fill_word_q <= '0;
         idle_flag_q <= 1'b0;
         ts_q        <= '0;
      end else begin
         if (slot_en) ts_q <= ts_q + TS_W'(1);
         if (dp_accept) fill_word_q <= dp_data;
         if (consume) idle_flag_q <= 1'b0;
         if (unused_slot) idle_flag_q <= 1'b1;
         if (fire && last_step) begin
            busy_q <= 1'b0;
            cmd_q  <= cmd_q & CMD_KEEP;
         end
         if (cfg_load) begin
            cmd_q <= cfg_cmd;
            if (cfg_go) busy_q <= 1'b1;
         end
         if (fill_go) busy_q <= 1'b1;
      end
   end

   assign q_push    = fire;
   assign q_addr    = dest_q;
   assign q_data    = value_w;
   assign q_cmd     = cmd_q;
   assign q_partial = partial_w;
   assign q_due     = ts_q + TS_W'(LATENCY);

   assign ext_addr  = src_q[22:0];
   assign busy      = busy_q;
   assign len_left  = len_q;
   assign cmd_now   = cmd_q;
   assign dest_now  = dest_q;

endmodule

// File: rtl/vdma_source_engine_chk.sv
module vdma_source_engine_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        slot_en,
   input logic [7:0]  slot_num,
   input logic        wide_mode,
   input logic        q_full,
   input logic        q_push,
   input logic        q_partial,
   input logic        busy,
   input logic [15:0] len_left,
   input logic [5:0]  cmd_now,
   input logic [1:0]  mode
);

   assert_push_in_slot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      q_push |-> (slot_en && busy));

   assert_bus_whole_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (q_push && !mode[1]) |-> !q_partial);

   assert_wide_refresh_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wide_mode && (slot_num == 8'd37 || slot_num >= 8'd210)) |-> !q_push);

   assert_narrow_refresh_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!wide_mode && slot_num == 8'd24) |-> !q_push);

   assert_fill_partial_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (q_push && mode == 2'b10) |-> q_partial);

   assert_no_push_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
      q_full |-> !q_push);

   assert_len_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      q_push |=> (len_left == $past(len_left) - 16'd1));

   assert_done_clears_go_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (cmd_now[5:4] == 2'b00));

endmodule

bind vdma_source_engine vdma_source_engine_chk u_chk (
   .clk(clk), .rst_n(rst_n), .slot_en(slot_en), .slot_num(slot_num),
   .wide_mode(wide_mode), .q_full(q_full), .q_push(q_push),
   .q_partial(q_partial), .busy(busy), .len_left(len_left),
   .cmd_now(cmd_now), .mode(mode_w)
);

// File: tb/vdma_source_engine_test.sv
module vdma_source_engine_test;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 20;
   // {wide, slot, full, expect_push}
   localparam logic [10:0] VEC [NV] = '{
      {1'b1, 8'd36,  1'b0, 1'b1}, {1'b1, 8'd37,  1'b0, 1'b0},
      {1'b1, 8'd38,  1'b0, 1'b0}, {1'b1, 8'd39,  1'b0, 1'b1},
      {1'b1, 8'd0,   1'b0, 1'b1}, {1'b1, 8'd209, 1'b0, 1'b1},
      {1'b1, 8'd210, 1'b0, 1'b0}, {1'b1, 8'd250, 1'b0, 1'b0},
      {1'b1, 8'd50,  1'b1, 1'b0}, {1'b0, 8'd24,  1'b0, 1'b0},
      {1'b0, 8'd25,  1'b0, 1'b0}, {1'b0, 8'd26,  1'b0, 1'b1},
      {1'b0, 8'd37,  1'b0, 1'b1}, {1'b0, 8'd210, 1'b0, 1'b1},
      {1'b1, 8'd103, 1'b0, 1'b0}, {1'b1, 8'd134, 1'b0, 1'b0},
      {1'b1, 8'd198, 1'b0, 1'b0}, {1'b0, 8'd153, 1'b0, 1'b0},
      {1'b1, 8'd69,  1'b0, 1'b0}, {1'b1, 8'd70,  1'b0, 1'b0}
   };

   logic clk = 0, rst_n = 0;
   logic slot_en = 0, wide_mode = 0, unused_slot = 0, cfg_load = 0, dp_wr = 0, q_full = 0;
   logic [7:0]  slot_num = 0, cfg_inc = 0;
   logic [23:0] cfg_src = 0;
   logic [15:0] cfg_len = 0, cfg_dest = 0, dp_data = 0;
   logic [5:0]  cfg_cmd = 0;
   logic dp_refused, ext_rd, loc_rd, q_push, q_partial, busy;
   logic [22:0] ext_addr;
   logic [15:0] ext_data, loc_addr, loc_data, q_addr, q_data, len_left, dest_now;
   logic [1:0]  loc_sel;
   logic [5:0]  q_cmd, cmd_now;
   logic [7:0]  q_due;

   assign ext_data = ext_addr[15:0] ^ 16'hC3A5;
   assign loc_data = loc_addr ^ {6'h15, loc_sel, 8'h3C};

   vdma_source_engine uut (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0, n_fail = 0, ts_model = 0;
   bit done = 0;
   logic c_push, c_partial, c_ref, c_locrd;
   logic [15:0] c_data, c_addr;
   logic [7:0] c_due;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input logic [7:0] s, input logic w, input logic un, input logic f,
                       input logic dw, input logic [15:0] dd);
      @(negedge clk);
      slot_en = 1; slot_num = s; wide_mode = w; unused_slot = un; q_full = f;
      dp_wr = dw; dp_data = dd;
      #1;
      c_push = q_push; c_partial = q_partial; c_data = q_data; c_addr = q_addr;
      c_due = q_due; c_ref = dp_refused; c_locrd = loc_rd;
      @(posedge clk);
      ts_model++;
      @(negedge clk);
      slot_en = 0; unused_slot = 0; q_full = 0; dp_wr = 0;
   endtask

   task automatic host_write(input logic [15:0] dd);
      @(negedge clk);
      dp_wr = 1; dp_data = dd;
      #1; c_ref = dp_refused;
      @(posedge clk);
      @(negedge clk);
      dp_wr = 0;
   endtask

   task automatic configure(input logic [23:0] s, input logic [15:0] l, input logic [7:0] inc,
                            input logic [15:0] d, input logic [5:0] c);
      @(negedge clk);
      cfg_load = 1; cfg_src = s; cfg_len = l; cfg_inc = inc; cfg_dest = d; cfg_cmd = c;
      @(posedge clk);
      @(negedge clk);
      cfg_load = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [15:0] e_src, e_dest, e_len;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;

      // R10 reset state
      chk("R10 busy", busy, 0);
      chk("R10 push", q_push, 0);
      chk("R10 len", len_left, 0);
      chk("R10 cmd", cmd_now, 0);

      // R9 bus transfer starts on load
      configure(24'h0120FE, 16'd100, 8'd2, 16'h0400, 6'h21);
      chk("R9 bus start", busy, 1);
      e_src = 16'h20FE; e_dest = 16'h0400; e_len = 16'd100;

      // R8 refused during bus run
      host_write(16'h1111);
      chk("R8 refused bus", c_ref, 1);

      // Table walk: R1 R2 R3 R6 R7
      for (int i = 0; i < NV; i++) begin
         tick(VEC[i][9:2], VEC[i][10], 1'b0, VEC[i][1], 1'b0, 16'h0);
         chk($sformatf("R2 R3 R6 push vec%0d", i), c_push, VEC[i][0]);
         if (VEC[i][0]) begin
            chk("R1 bus data", c_data, e_src ^ 16'hC3A5);
            chk("R1 bus partial", c_partial, 0);
            chk("R7 dest", c_addr, e_dest);
            chk("R6 due", c_due, 8'(ts_model - 1 + 3));
            e_src = e_src + 1; e_dest = e_dest + 2; e_len = e_len - 1;
            chk("R7 src carry", ext_addr[15:0], e_src);
            chk("R7 len", len_left, e_len);
         end
      end

      // R7 end of length clears run and go bits
      configure(24'h000010, 16'd2, 8'd1, 16'h0000, 6'h21);
      tick(8'd5, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
      chk("R7 first push", c_push, 1);
      chk("R7 still busy", busy, 1);
      tick(8'd6, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
      chk("R7 last push", c_push, 1);
      chk("R7 busy low", busy, 0);
      chk("R7 cmd cleared", cmd_now, 6'h01);
      chk("R7 len zero", len_left, 0);
      tick(8'd7, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
      chk("R7 no push after end", c_push, 0);

      // R5 fill, main RAM target
      configure(24'h800000, 16'd3, 8'd1, 16'h0010, 6'h21);
      chk("R9 fill waits", busy, 0);
      tick(8'd5, 1'b1, 1'b0, 1'b0, 1'b1, 16'hABCD);
      chk("R5 no push in trigger slot", c_push, 0);
      chk("R8 fill trigger accepted", c_ref, 0);
      chk("R5 fill busy", busy, 1);
      tick(8'd6, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
      chk("R5 fill push", c_push, 1);
      chk("R5 fill high byte", c_data, 16'h00AB);
      chk("R5 fill partial", c_partial, 1);
      chk("R5 fill dest", c_addr, 16'h0010);
      host_write(16'h1234);
      chk("R8 accepted during fill", c_ref, 0);
      tick(8'd7, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
      chk("R5 refill data", c_data, 16'h0012);

      // R5 fill, colour RAM target uses full word
      configure(24'h800000, 16'd1, 8'd2, 16'h0020, 6'h23);
      host_write(16'h5A5A);
      tick(8'd8, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
      chk("R5 colour fill push", c_push, 1);
      chk("R5 colour fill word", c_data, 16'h5A5A);
      chk("R7 colour fill done", busy, 0);

      // R4 copy, main RAM
      configure(24'hC00340, 16'd5, 8'd1, 16'h0000, 6'h21);
      tick(8'd5, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
      chk("R4 copy waits for idle slot", c_push, 0);
      tick(8'd6, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0);
      chk("R4 no push in flag slot", c_push, 0);
      tick(8'd7, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
      chk("R4 copy push", c_push, 1);
      chk("R4 copy main data", c_data, 16'h0340 ^ 16'h543C);
      tick(8'd8, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
      chk("R4 flag consumed", c_push, 0);

      // R4 scroll copy out of range and in range
      configure(24'hC0002D, 16'd4, 8'd1, 16'h0000, 6'h25);
      tick(8'd5, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0);
      tick(8'd6, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
      chk("R4 scroll oob push", c_push, 1);
      chk("R4 scroll oob zero", c_data, 0);
      chk("R4 scroll oob no read", c_locrd, 0);
      configure(24'hC00005, 16'd4, 8'd1, 16'h0000, 6'h25);
      tick(8'd5, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0);
      tick(8'd6, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
      chk("R4 scroll data", c_data, 16'h0005 ^ 16'h563C);

      // R4 colour copy masks to depth
      configure(24'hC00047, 16'd4, 8'd1, 16'h0000, 6'h23);
      tick(8'd5, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0);
      tick(8'd6, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
      chk("R4 colour copy data", c_data, 16'h0007 ^ 16'h553C);
      host_write(16'h2222);
      chk("R8 refused during copy", c_ref, 1);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule